// File: doc/BRIEF.md
# Self-Test Unlock Register

This block is an 8-bit control register on a simple peripheral write bus. It guards entry to the self-test mode of a serial communication controller. The self-test flag is set only after software writes a fixed three-byte key to the register's address on three consecutive writes to that address, and only while the controller's operating-mode bit shows that it is in reset mode.

The flag comes out on a dedicated output for the controller. The controller's mode logic clears it with an exit input, and a system reset also clears it. Reads return the flag in bit 0 and zero in every other bit.

The reset input is asserted asynchronously. Inside the block its release is synchronised to the clock.

Top module: `selftest_unlock_reg`

## Requirements
- R1: After reset the register reads 00h and `o_selftest` is 0.
- R2: The bytes A7h, 58h and 01h, written in that order on consecutive writes to the register address, set the flag. `o_selftest` and read bit 0 become 1 on the clock edge that captures the 01h write.
- R3: A write to the register address while `i_opmode_bit` is 1 (not reset mode) cannot set the flag. It also returns the key tracker to its start state, so a key that was partly entered must begin again.
- R4: A write to the register address that is not the next expected key byte returns the tracker to its start state. If that write is A7h, it counts as the first key byte.
- R5: A write with bit 0 set that does not complete the key, such as a lone 01h, leaves the register unchanged.
- R6: Read data bits 6 to 1 are always 0. Bit 7 is driven to 0, and the bench treats it as don't-care.
- R7: `i_exit` high at a clock edge clears the flag. It takes priority over a key completing on the same edge.
- R8: Once the flag is set, later writes do not change it.
- R9: Writes to any other address neither advance nor abort a key sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_wr | input | 1 | Write strobe, one write per cycle it is high |
| i_addr | input | ADDR_W | Write address |
| i_wdata | input | 8 | Write data |
| i_opmode_bit | input | 1 | Controller operating-mode bit, 0 = reset mode |
| i_exit | input | 1 | Clears the self-test flag |
| o_rdata | output | 8 | Register read value |
| o_selftest | output | 1 | Self-test mode flag |

## Verification
The assertions assume that `i_wr`, `i_addr`, `i_wdata`, `i_opmode_bit` and `i_exit` are stable around each rising clock edge and never X after reset. They also assume that `i_exit` is a short pulse and not a level that is held during key entry. The bench changes every input only on the falling clock edge. It raises `i_exit` only between tests, with one exception: a test that deliberately makes it coincide with the final key write. Sweeps replace each key position with every byte value from 00h to FFh. The expected flag for each case is computed in the bench by comparing the byte against the key.

// File: rtl/selftest_unlock_pkg.sv
package selftest_unlock_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_B0 = 8'hA7;
  localparam logic [DATA_W-1:0] KEY_B1 = 8'h58;
  localparam logic [DATA_W-1:0] KEY_B2 = 8'h01;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_ONE  = 2'd1,
    TRK_TWO  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/stu_rst_sync.sv
module stu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/stu_key_tracker.sv
module stu_key_tracker
  import selftest_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_hit,
  input  logic [DATA_W-1:0] i_wdata,
  input  logic              i_in_reset_mode,
  output logic              o_done
);
  trk_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (i_hit) begin
      if (!i_in_reset_mode) begin
        state_d = TRK_IDLE;
      end else begin
        unique case (state_q)
          TRK_IDLE: state_d = (i_wdata == KEY_B0) ? TRK_ONE : TRK_IDLE;
          TRK_ONE:  state_d = (i_wdata == KEY_B1) ? TRK_TWO :
                              (i_wdata == KEY_B0) ? TRK_ONE : TRK_IDLE;
          TRK_TWO: begin
            if (i_wdata == KEY_B2) begin
              done_d  = 1'b1;
              state_d = TRK_IDLE;
            end else begin
              state_d = (i_wdata == KEY_B0) ? TRK_ONE : TRK_IDLE;
            end
          end
          default: state_d = TRK_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= TRK_IDLE;
    else if (i_hit) state_q <= state_d;
  end

  assign o_done = done_d;

  assert_idle_outside_reset_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_hit && !i_in_reset_mode) |=> (state_q == TRK_IDLE));
  assert_no_done_outside_reset_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !i_in_reset_mode |-> !o_done);
  assert_other_addr_holds_tracker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !i_hit |=> $stable(state_q));
  assert_a7_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (i_hit && i_in_reset_mode && i_wdata == KEY_B0) |=> (state_q == TRK_ONE));
endmodule

// File: rtl/stu_mode_flag.sv
module stu_mode_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic i_set,
  input  logic i_exit,
  output logic o_flag
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = i_exit | i_set;
    flag_d  = i_exit ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign o_flag = flag_q;

  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    i_exit |=> !o_flag);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_flag && !i_exit) |=> o_flag);
  assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_flag) |-> $past(i_set));
endmodule

// File: rtl/selftest_unlock_reg.sv
module selftest_unlock_reg
  import selftest_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_wr,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic [7:0]        i_wdata,
  input  logic              i_opmode_bit,
  input  logic              i_exit,
  output logic [7:0]        o_rdata,
  output logic              o_selftest
);
  localparam int unsigned PAD_W = DATA_W - 1;

  logic rst_n_int;
  logic hit;
  logic key_done;
  logic flag;

  stu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign hit = i_wr && (i_addr == REG_ADDR);

  stu_key_tracker u_trk (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .i_hit           (hit),
    .i_wdata         (i_wdata),
    .i_in_reset_mode (~i_opmode_bit),
    .o_done          (key_done)
  );

  stu_mode_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .i_set  (key_done),
    .i_exit (i_exit),
    .o_flag (flag)
  );

  assign o_rdata    = {{PAD_W{1'b0}}, flag};
  assign o_selftest = flag;

  assert_lone_01_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (hit && i_wdata == KEY_B2 && !key_done && !o_selftest) |=> !o_selftest);
  assert_busy_mode_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (hit && i_opmode_bit && !o_selftest) |=> !o_selftest);
  assert_rdata_tracks_flag_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    o_rdata[0] == o_selftest);
endmodule

// File: tb/selftest_unlock_reg_tb.sv
module selftest_unlock_reg_tb;
  localparam logic [3:0] A_REG = 4'h4;
  localparam logic [3:0] A_OTH = 4'h9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       i_wr;
  logic [3:0] i_addr;
  logic [7:0] i_wdata;
  logic       i_opmode_bit;
  logic       i_exit;
  logic [7:0] o_rdata;
  logic       o_selftest;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  selftest_unlock_reg u_dut (
    .clk(clk), .rst_n(rst_n), .i_wr(i_wr), .i_addr(i_addr), .i_wdata(i_wdata),
    .i_opmode_bit(i_opmode_bit), .i_exit(i_exit), .o_rdata(o_rdata), .o_selftest(o_selftest)
  );

  task automatic check(input string req, input logic exp_flag);
    n_chk++;
    if (o_selftest !== exp_flag || o_rdata[6:1] !== 6'd0 || o_rdata[0] !== exp_flag) begin
      n_bad++;
      $display("FAIL %s: flag=%b rdata=%h expected flag=%b rdata[6:0]=%h",
               req, o_selftest, o_rdata, exp_flag, {6'd0, exp_flag});
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic busy);
    @(negedge clk);
    i_wr = 1'b1; i_addr = a; i_wdata = d; i_opmode_bit = busy;
    @(negedge clk);
    i_wr = 1'b0; i_opmode_bit = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk);
    i_exit = 1'b1;
    @(negedge clk);
    i_exit = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i_wr = 1'b0; i_addr = '0; i_wdata = '0; i_opmode_bit = 1'b0; i_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset value", 1'b0);

    // R2 plain key; R8 later writes keep it
    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h58, 0); check("R2 not after two bytes", 1'b0);
    wr(A_REG, 8'h01, 0); check("R2 key sets flag", 1'b1);
    wr(A_REG, 8'h00, 0); wr(A_REG, 8'hFE, 0); check("R8 writes keep flag", 1'b1);
    wr(A_REG, 8'h01, 1); check("R8 busy write keeps flag", 1'b1);
    do_exit(); check("R7 exit clears", 1'b0);

    // Sweeps over every byte in each key position (R2/R4)
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b0, b1, b2;
        logic exp;
        b0 = (p == 0) ? 8'(v) : 8'hA7;
        b1 = (p == 1) ? 8'(v) : 8'h58;
        b2 = (p == 2) ? 8'(v) : 8'h01;
        exp = (b0 == 8'hA7) && (b1 == 8'h58) && (b2 == 8'h01);
        // a mismatching middle byte of A7 restarts, so A7,A7,01 stays clear too
        wr(A_REG, b0, 0); wr(A_REG, b1, 0); wr(A_REG, b2, 0);
        check("R4 sweep", exp);
        do_exit();
      end
    end

    wr(A_REG, 8'h58, 0); wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h01, 0);
    check("R4 wrong order", 1'b0);
    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h58, 0); wr(A_REG, 8'h01, 0);
    check("R4 repeated A7 restarts", 1'b1);
    do_exit();
    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h00, 0); wr(A_REG, 8'h58, 0); wr(A_REG, 8'h01, 0);
    check("R4 abort then tail", 1'b0);

    wr(A_REG, 8'hA7, 1); wr(A_REG, 8'h58, 1); wr(A_REG, 8'h01, 1);
    check("R3 key outside reset mode", 1'b0);
    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h58, 0); wr(A_REG, 8'h01, 1);
    check("R3 last byte busy", 1'b0);
    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h33, 1); wr(A_REG, 8'h58, 0); wr(A_REG, 8'h01, 0);
    check("R3 busy write resets tracker", 1'b0);

    wr(A_REG, 8'h01, 0); check("R5 lone 01", 1'b0);
    wr(A_REG, 8'hFF, 0); check("R5 FF write", 1'b0);

    wr(A_REG, 8'hA7, 0); wr(A_OTH, 8'h00, 0); wr(A_OTH, 8'h01, 0);
    wr(A_REG, 8'h58, 0); wr(A_OTH, 8'hA7, 0); wr(A_REG, 8'h01, 0);
    check("R9 other addresses ignored", 1'b1);
    do_exit();
    wr(A_OTH, 8'hA7, 0); wr(A_OTH, 8'h58, 0); wr(A_OTH, 8'h01, 0);
    check("R9 key at other address", 1'b0);

    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h58, 0);
    @(negedge clk);
    i_wr = 1'b1; i_addr = A_REG; i_wdata = 8'h01; i_exit = 1'b1;
    @(negedge clk);
    i_wr = 1'b0; i_exit = 1'b0;
    check("R7 exit beats completion", 1'b0);

    check("R6 read bits 6..1 zero", 1'b0);
    wr(A_REG, 8'hA7, 0); wr(A_REG, 8'h58, 0); wr(A_REG, 8'h01, 0);
    check("R6 read with flag set", 1'b1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset clears", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule